// File: doc/BRIEF.md
# ADC conversion control sequencer

This block is the digital control side of a successive-approximation converter. One 8-bit control/status word holds a converter enable, a start request, a free-running select, a completion flag with its interrupt enable, and a 3-bit select for the clock divider. Software reaches the word through a plain register port: the address decode is done outside, so there is a write strobe with write data and a read-data output. A second pair of byte ports returns the 10-bit result.

The block divides the system clock down to a one-cycle ADC clock enable. It counts conversions in units of that enable and captures the converter's sampled word. After that it loads the result, raises the completion flag and requests an interrupt when the interrupt enable and the global enable allow it. The first start after the converter is switched on is preceded by an initialization pass. The start bit drops one ADC clock before the result is loaded, so software can queue the next conversion without a gap. The analog comparator and DAC are not part of the block. A converter model, or the bench, drives the sampled word.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Clearing the enable bit (bit 7) stops the ADC clock enable at once, clears the start bit and abandons a running conversion without setting the flag or loading the result.
- R2: With free-run (bit 5) at 0, each conversion needs its own write of 1 to the start bit (bit 6) and takes 13 ADC clocks, with the flag set on the 14th. With free-run at 1, one start gives back-to-back conversions, the flag sets every 13 ADC clocks and the start bit stays 1.
- R3: The first start after enable, including a start written together with enable, first runs a 12-clock initialization pass. The start bit then stays 1 for 25 ADC clocks and the flag sets on the 26th.
- R4: The start bit falls on the last ADC clock of a real conversion, one ADC clock before the flag and the result. A start written in that gap begins the next conversion on the load clock, and that conversion's flag follows 13 ADC clocks after the previous flag.
- R5: Writing 0 to the start bit has no effect. Clearing free-run lets the running conversion finish and then stops.
- R6: The flag (bit 4) sets on the same ADC clock that loads the result. A write with bit 4 at 1 clears it, and so does a pulse on irq_ack. A set in the same cycle wins over a clear.
- R7: irq is 1 exactly when the flag, the interrupt enable (bit 3) and glob_ie are all 1.
- R8: The prescale select (bits 2:0) divides the system clock by 2, 2, 4, 8, 16, 32, 64 or 128 for the codes 0 to 7. The ADC clock enable is a one-cycle pulse every that many cycles, and the first pulse comes that many cycles after the enabling write.
- R9: Reset clears all eight control bits and the result, and irq and adc_clk_en are 0.
- R10: The result is the conv_sample value present at ADC clock 1 of the real conversion, where clock 0 is the first clock of that conversion. It is read as res_lo = bits 7:0 and res_hi = bits 9:8 in its low two bits, upper bits 0.
- R11: A register write with bit 4 at 0 leaves a pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Control/status word read-back |
| glob_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| conv_sample | input | 10 | Sampled word from the converter model |
| adc_clk_en | output | 1 | One-cycle ADC clock enable pulse |
| res_lo | output | 8 | Result bits 7:0 |
| res_hi | output | 8 | Result bits 9:8 in bits 1:0 |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
Conversions are run from a fresh enable, repeated in single mode, queued inside the start-to-load gap, and chained in free-run mode. The ADC clock count to each start-bit fall and each flag rise separates the 26-clock first pass from the 13-clock and 14-clock cases, and shows whether the initialization pass runs only once. The sampled word changes on every ADC clock, so the loaded result shows which clock was captured. Random prescale codes with counted system cycles check the divider map. Disabling in the middle of a conversion, zero writes to the start and flag bits, and acknowledge pulses show that the abort and the flag clear paths take only their own triggers.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CSR_W = 8;
    localparam int PS_W  = 3;
    localparam int DIV_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INIT,
        ST_CONV,
        ST_LOAD
    } conv_state_e;

    // Field order is the bit order of the control/status word (MSB first).
    typedef struct packed {
        logic            en;
        logic            start;
        logic            frun;
        logic            flag;
        logic            ie;
        logic [PS_W-1:0] ps;
    } csr_t;

    // Divide factor for a prescale code: code 0 and code 1 both divide by 2.
    function automatic logic [DIV_W-1:0] div_of(input logic [PS_W-1:0] ps);
        if (ps == '0) return DIV_W'(2);
        return DIV_W'(1 << ps);
    endfunction

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    assign limit = div_of(ps) - DIV_W'(1);
    assign tick  = en && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/adc_csr.sv
module adc_csr
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CSR_W-1:0] wdata,
    input  logic             conv_clr,
    input  logic             load_done,
    input  logic             irq_ack,
    output csr_t             q
);
    csr_t w;
    csr_t d;

    assign w = csr_t'(wdata);

    always_comb begin
        d = q;
        if (conv_clr) d.start = 1'b0;
        if (irq_ack)  d.flag  = 1'b0;
        if (we) begin
            d.en   = w.en;
            d.frun = w.frun;
            d.ie   = w.ie;
            d.ps   = w.ps;
            if (w.start) d.start = 1'b1;   // a written 0 changes nothing
            if (w.flag)  d.flag  = 1'b0;   // write-one-to-clear
        end
        if (!d.en)     d.start = 1'b0;
        if (load_done) d.flag  = 1'b1;     // set wins over clear
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int INIT_LEN   = 12,
    parameter int CONV_LEN   = 13,
    parameter int SAMPLE_IDX = 1      // must be at least 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             start,
    input  logic             frun,
    input  logic [RES_W-1:0] sample,
    output logic             conv_clr,
    output logic             load_done,
    output logic [RES_W-1:0] result
);
    localparam int MAX_LEN = (INIT_LEN > CONV_LEN) ? INIT_LEN : CONV_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_LEN - 1);
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_LEN - 1);
    localparam logic [CNT_W-1:0] SAMP_AT   = CNT_W'(SAMPLE_IDX);

    conv_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic             init_done;
    logic [RES_W-1:0] hold;

    assign conv_clr  = tick && (state == ST_CONV) && (cnt == CONV_LAST) && !frun;
    assign load_done = tick && (state == ST_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            init_done <= 1'b0;
            hold      <= '0;
            result    <= '0;
        end else if (!en) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            init_done <= 1'b0;
        end else if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cnt   <= CNT_W'(1);
                        state <= init_done ? ST_CONV : ST_INIT;
                    end
                end
                ST_INIT: begin
                    if (cnt == INIT_LAST) begin
                        state     <= ST_CONV;
                        cnt       <= '0;
                        init_done <= 1'b1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_CONV: begin
                    if (cnt == SAMP_AT) hold <= sample;
                    if (cnt == CONV_LAST) state <= ST_LOAD;
                    else                  cnt   <= cnt + CNT_W'(1);
                end
                ST_LOAD: begin
                    result <= hold;
                    if (start) begin
                        state <= ST_CONV;
                        cnt   <= CNT_W'(1);
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int INIT_LEN   = 12,
    parameter int CONV_LEN   = 13,
    parameter int SAMPLE_IDX = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_we,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             glob_ie,
    input  logic             irq_ack,
    input  logic [RES_W-1:0] conv_sample,
    output logic             adc_clk_en,
    output logic [7:0]       res_lo,
    output logic [7:0]       res_hi,
    output logic             irq
);
    csr_t             q;
    logic             tick;
    logic             conv_clr;
    logic             load_done;
    logic [RES_W-1:0] result;
    logic [15:0]      res_ext;

    adc_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .en   (q.en),
        .ps   (q.ps),
        .tick (tick)
    );

    adc_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .we        (csr_we),
        .wdata     (csr_wdata),
        .conv_clr  (conv_clr),
        .load_done (load_done),
        .irq_ack   (irq_ack),
        .q         (q)
    );

    adc_conv_fsm #(
        .RES_W      (RES_W),
        .INIT_LEN   (INIT_LEN),
        .CONV_LEN   (CONV_LEN),
        .SAMPLE_IDX (SAMPLE_IDX)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (q.en),
        .tick      (tick),
        .start     (q.start),
        .frun      (q.frun),
        .sample    (conv_sample),
        .conv_clr  (conv_clr),
        .load_done (load_done),
        .result    (result)
    );

    assign res_ext    = 16'(result);
    assign res_lo     = res_ext[7:0];
    assign res_hi     = res_ext[15:8];
    assign csr_rdata  = q;
    assign adc_clk_en = tick;
    assign irq        = q.flag & q.ie & glob_ie;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       we,
    input logic       w_start,
    input logic       w_flag,
    input logic [7:0] rd,
    input logic       gie,
    input logic       ack,
    input logic       tick,
    input logic       irq
);
    // R9
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (rd == 8'h00) && !irq);

    // R1
    p_off_no_clk_r1: assert property (@(posedge clk) disable iff (rst)
        !rd[7] |-> !tick);

    // R7
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (gie && rd[4] && rd[3]));

    // R11
    p_flag_keep_r11: assert property (@(posedge clk) disable iff (rst)
        (rd[4] && we && !w_flag && !ack) |=> rd[4]);

    // R6
    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        (we && w_flag && !tick) |=> !rd[4]);

    // R6
    p_flag_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rd[4]) |-> $past(tick));

    // R5
    p_start_w0_r5: assert property (@(posedge clk) disable iff (rst)
        (!rd[6] && we && !w_start) |=> !rd[6]);
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .we      (csr_we),
    .w_start (csr_wdata[6]),
    .w_flag  (csr_wdata[4]),
    .rd      (csr_rdata),
    .gie     (glob_ie),
    .ack     (irq_ack),
    .tick    (adc_clk_en),
    .irq     (irq)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       csr_we = 1'b0;
    logic [7:0] csr_wdata = 8'h00;
    logic [7:0] csr_rdata;
    logic       glob_ie = 1'b0;
    logic       irq_ack = 1'b0;
    logic [9:0] conv_sample;
    logic       adc_clk_en;
    logic [7:0] res_lo;
    logic [7:0] res_hi;
    logic       irq;

    int tests = 0;
    int fails = 0;
    int tick_n = 0;
    int cyc = 0;
    int cur_div = 2;
    int per_err = 0;
    int last_tick = 0;
    bit last_ok = 1'b0;

    always #4 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .glob_ie(glob_ie), .irq_ack(irq_ack),
        .conv_sample(conv_sample), .adc_clk_en(adc_clk_en),
        .res_lo(res_lo), .res_hi(res_hi), .irq(irq)
    );

    function automatic int sval(input int n);
        return ((n * 97) + 13 ^ (n * 5)) & 1023;
    endfunction

    function automatic int div_tb(input int ps);
        return (ps == 0) ? 2 : (1 << ps);
    endfunction

    assign conv_sample = 10'(sval(tick_n));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (adc_clk_en) tick_n <= tick_n + 1;
    end

    // Tick spacing against the expected divide (R8)
    always @(negedge clk) begin
        if (!csr_rdata[7]) last_ok = 1'b0;
        else if (adc_clk_en) begin
            if (last_ok && (cyc - last_tick != cur_div)) per_err++;
            last_tick = cyc;
            last_ok = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        csr_we = 1'b1;
        csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
        csr_wdata = 8'h00;
    endtask

    task automatic wait_bit(input int b, input logic v, input string req);
        int n = 0;
        while (csr_rdata[b] !== v && n < 40000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 40000) chk(1'b0, {req, " timeout"}, n, 0);
    endtask

    function automatic int res_val();
        return int'({res_hi[1:0], res_lo});
    endfunction

    int n0;
    int c0;
    int lf;

    initial begin
        void'($urandom(32'h5eed_2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(csr_rdata == 8'h00, "R9 ctrl", csr_rdata, 0);
        chk(res_lo == 0 && res_hi == 0, "R9 result", res_val(), 0);
        chk(!irq && !adc_clk_en, "R9 irq/clk", {irq, adc_clk_en}, 0);

        // First conversion with enable and start together: init pass
        cur_div = 2;
        wr(8'hC0);
        n0 = tick_n;
        wait_bit(6, 1'b0, "R3");
        chk(tick_n - n0 == 25, "R3 start high length", tick_n - n0, 25);
        chk(csr_rdata[4] == 1'b0, "R4 start falls before flag", csr_rdata[4], 0);
        wait_bit(4, 1'b1, "R4");
        chk(tick_n - n0 == 26, "R4 flag after first pass", tick_n - n0, 26);
        chk(res_val() == sval(n0 + 13), "R10 first sample", res_val(), sval(n0 + 13));

        // Interrupt gating and flag keep on a zero write
        glob_ie = 1'b0;
        wr(8'h88);
        chk(csr_rdata[4] == 1'b1, "R11 flag kept", csr_rdata[4], 1);
        chk(irq == 1'b0, "R7 gie off", irq, 0);
        glob_ie = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R7 all set", irq, 1);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk(csr_rdata[4] == 1'b0 && irq == 1'b0, "R6 ack clears", {csr_rdata[4], irq}, 0);

        // Writing 0 to start does nothing
        wr(8'h80);
        repeat (100) @(negedge clk);
        chk(csr_rdata[6] == 1'b0 && csr_rdata[4] == 1'b0, "R5 zero start",
            {csr_rdata[6], csr_rdata[4]}, 0);

        // Second single conversion: no init pass
        wr(8'hC0);
        n0 = tick_n;
        wait_bit(4, 1'b1, "R2");
        chk(tick_n - n0 == 14, "R2 single length", tick_n - n0, 14);
        chk(res_val() == sval(n0 + 1), "R10 repeat sample", res_val(), sval(n0 + 1));
        wr(8'h90);
        chk(csr_rdata[4] == 1'b0, "R6 write one clears", csr_rdata[4], 0);

        // Start queued in the start-to-load gap
        wr(8'hC0);
        n0 = tick_n;
        wait_bit(6, 1'b0, "R4");
        chk(tick_n - n0 == 13, "R4 start fall", tick_n - n0, 13);
        wr(8'hC0);
        wait_bit(4, 1'b1, "R4");
        lf = tick_n;
        chk(lf - n0 == 14, "R4 first flag", lf - n0, 14);
        chk(csr_rdata[6] == 1'b1, "R4 queued start", csr_rdata[6], 1);
        wr(8'h90);
        wait_bit(4, 1'b1, "R4");
        chk(tick_n - lf == 13, "R4 queued flag", tick_n - lf, 13);
        chk(res_val() == sval(lf), "R10 queued sample", res_val(), sval(lf));
        wr(8'h90);

        // Free-run
        wait_bit(6, 1'b0, "R2");
        wr(8'hE0);
        n0 = tick_n;
        wait_bit(4, 1'b1, "R2");
        chk(tick_n - n0 == 14, "R2 free-run first", tick_n - n0, 14);
        for (int k = 0; k < 2; k++) begin
            lf = tick_n;
            wr(8'hB0);
            wait_bit(4, 1'b1, "R2");
            chk(tick_n - lf == 13, "R2 free-run period", tick_n - lf, 13);
            chk(csr_rdata[6] == 1'b1, "R2 start held", csr_rdata[6], 1);
        end
        wr(8'h90);
        wait_bit(4, 1'b1, "R5");
        chk(csr_rdata[6] == 1'b0, "R5 free-run stops", csr_rdata[6], 0);
        wr(8'h90);
        repeat (100) @(negedge clk);
        chk(csr_rdata[4] == 1'b0, "R5 no more flags", csr_rdata[4], 0);

        // Abort by disable
        wr(8'hC0);
        repeat (12) @(negedge clk);
        wr(8'h00);
        chk(csr_rdata[6] == 1'b0, "R1 start cleared", csr_rdata[6], 0);
        n0 = tick_n;
        repeat (60) @(negedge clk);
        chk(tick_n == n0, "R1 clock stopped", tick_n - n0, 0);
        chk(csr_rdata[4] == 1'b0, "R1 no flag", csr_rdata[4], 0);
        wr(8'hC0);
        n0 = tick_n;
        wait_bit(4, 1'b1, "R3");
        chk(tick_n - n0 == 26, "R3 init again", tick_n - n0, 26);
        wr(8'h10);

        // Random prescale codes
        for (int i = 0; i < 8; i++) begin
            int ps;
            ps = (i < 2) ? (i == 0 ? 7 : 1) : int'($urandom % 8);
            cur_div = div_tb(ps);
            per_err = 0;
            wr(8'hC0 | 8'(ps));
            n0 = tick_n;
            c0 = cyc;
            wait_bit(4, 1'b1, "R8");
            chk(cyc - c0 == 26 * cur_div, "R8 cycles to flag", cyc - c0, 26 * cur_div);
            chk(per_err == 0, "R8 tick spacing", per_err, 0);
            chk(res_val() == sval(n0 + 13), "R10 random sample", res_val(), sval(n0 + 13));
            wr(8'h10);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 190000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule